// File: doc/BRIEF.md
# Card Controller Event Status Register

This block collects the one-cycle event strobes produced by the command and data engines of a memory-card host controller. Each strobe sets a sticky bit in a 32-bit status word that the CPU reads on a read port. Most bits are cleared by the CPU read. The receive-ready and transmit-ready flags are different: they follow the state of the data registers and ignore status reads.

A two-flop synchronizer and edge detector on the card's DAT3 line sets a card-detect bit when either edge is seen. An interrupt level is raised when a status bit goes from 0 to 1 while its mask bit is set. The level stays high until the status read, or the fall of that flag, retires the pending rise.

The bit positions are fixed because the rest of the controller decodes them. Bit 13 is command complete and bit 12 is transfer done (last byte of the programmed length moved). Bit 11 is the DAT3 edge, bit 10 is receive ready and bit 9 is transmit ready. Bits 7 down to 0 are, from high to low: response CRC error, read CRC error, write CRC error, response timeout, read timeout, response done, busy done and data done. Data done comes later than transfer done, after the CRC check and card programming finish.

Top module: `cardEvtStatus`

## Requirements
- R1: `statRdData` bits 31..14 and bit 8 always read 0. Bit 13 is command complete, 12 transfer done, 11 DAT3 edge, 10 receive ready, 9 transmit ready, and bits 7..0 equal the sticky copies of `evStrobe[7..0]`.
- R2: After reset `statRdData` is 32'h0000_0200, so only transmit ready is set, and `irq` is 0.
- R3: A strobe on `evStrobe[i]`, `cmdDone` or `xferDone` sets its bit, visible in the cycle after the strobe. The bit stays set until a status read.
- R4: While `statRd` is high, `statRdData` shows the value before the clear. In the next cycle, every bit except 10 and 9 is 0 unless a new event set it.
- R5: An event strobe in the same cycle as `statRd` leaves its bit set after the read.
- R6: Receive ready (bit 10) sets on `rxLoad`. It clears on `rxRead`, `dataRst` or `cmdDataClr`. `dataRst` and `cmdDataClr` win over `rxLoad`, and `rxLoad` wins over `rxRead`.
- R7: Transmit ready (bit 9) clears on `txWrite`. It sets on `txDrain`, `dataRst` or `cmdDataClr`, and a set wins over `txWrite` in the same cycle.
- R8: A rising or falling change of `dat3In` sets bit 11 on the third clock edge after the change, but not earlier.
- R9: A 0-to-1 change of a status bit makes that bit pending. `irq` is high whenever some pending bit has its `intMask` bit set. A bit that a read clears while an event sets it again counts as a new rise.
- R10: A status read retires every pending bit, including those of bits 10 and 9, which stay set without raising `irq` again. A flag that falls also retires its pending state.
- R11: `intMask` gates `irq` combinationally. With a zero mask `irq` is 0, and setting a mask bit over a pending bit raises `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStrobe | input | 8 | Event strobes for status bits 7..0 |
| cmdDone | input | 1 | Command completion strobe (bit 13) |
| xferDone | input | 1 | Last byte of programmed length moved (bit 12) |
| rxLoad | input | 1 | New data written into the receive data register |
| rxRead | input | 1 | Receive data register read |
| dataRst | input | 1 | Data logic reset |
| cmdDataClr | input | 1 | Command issued with its data-clear flag set |
| txWrite | input | 1 | Transmit data register written |
| txDrain | input | 1 | Transmit data register emptied by the data engine |
| dat3In | input | 1 | Asynchronous DAT3 line |
| statRd | input | 1 | CPU status read strobe |
| intMask | input | 14 | Interrupt mask, one bit per status bit |
| statRdData | output | 32 | Status word |
| irq | output | 1 | Interrupt request level |

## Verification
Strobe, flag and read effects are registered once, so they appear in `statRdData` one clock edge after the cycle that carried them. A DAT3 change takes three edges. `irq` follows the pending bits with no added register and follows a change of `intMask` in the same cycle. The bench drives inputs just after the falling edge and advances one rising edge. It then compares the outputs at the next falling edge against a cycle model updated with the same inputs. For DAT3 it also checks the outputs explicitly two and three edges after the change.

// File: rtl/cardEvtPkg.sv
package cardEvtPkg;
  localparam int STAT_W  = 14;
  localparam int EV_W    = 8;
  localparam int BIT_CMD = 13;
  localparam int BIT_XFR = 12;
  localparam int BIT_D3  = 11;
  localparam int BIT_RX  = 10;
  localparam int BIT_TX  = 9;
  localparam int BIT_RSV = 8;

  // bits that survive a status read
  localparam logic [STAT_W-1:0] HOLD_MASK = (STAT_W'(1) << BIT_RX) | (STAT_W'(1) << BIT_TX);
  // bits that exist
  localparam logic [STAT_W-1:0] LIVE_MASK = ~(STAT_W'(1) << BIT_RSV);
  localparam logic [STAT_W-1:0] RESET_VAL = STAT_W'(1) << BIT_TX;

  typedef struct packed {
    logic [STAT_W-1:0] setVec;
    logic [STAT_W-1:0] clrVec;
    logic              rdClr;
  } evtStrobe_t;
endpackage

// File: rtl/cardEvtCtrl.sv
module cardEvtCtrl
  import cardEvtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EV_W-1:0]   evStrobe,
  input  logic              cmdDone,
  input  logic              xferDone,
  input  logic              rxLoad,
  input  logic              rxRead,
  input  logic              dataRst,
  input  logic              cmdDataClr,
  input  logic              txWrite,
  input  logic              txDrain,
  input  logic              dat3In,
  input  logic              statRd,
  output evtStrobe_t        strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   dat3LastQ;
  logic                   dat3Edge;
  logic                   dataClr;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= dat3In;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) dat3LastQ <= 1'b0;
    else       dat3LastQ <= syncQ[TOP];
  end

  assign dat3Edge = syncQ[TOP] ^ dat3LastQ;
  assign dataClr  = dataRst | cmdDataClr;

  always_comb begin
    strobe = '0;
    strobe.setVec[EV_W-1:0] = evStrobe;
    strobe.setVec[BIT_CMD]  = cmdDone;
    strobe.setVec[BIT_XFR]  = xferDone;
    strobe.setVec[BIT_D3]   = dat3Edge;
    // receive ready: data clear beats load, load beats register read
    strobe.setVec[BIT_RX]   = rxLoad & ~dataClr;
    strobe.clrVec[BIT_RX]   = dataClr | rxRead;
    // transmit ready: any set beats a register write
    strobe.setVec[BIT_TX]   = txDrain | dataClr;
    strobe.clrVec[BIT_TX]   = txWrite;
    strobe.rdClr            = statRd;
  end
endmodule

// File: rtl/cardEvtPath.sv
module cardEvtPath
  import cardEvtPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strobe,
  input  logic [STAT_W-1:0] intMask,
  output logic [DATA_W-1:0] statRdData,
  output logic              irq
);
  logic [STAT_W-1:0] statQ, statD, baseVal;
  logic [STAT_W-1:0] pendQ, pendD;

  always_comb begin
    baseVal = strobe.rdClr ? (statQ & HOLD_MASK) : statQ;
    statD   = ((baseVal & ~strobe.clrVec) | strobe.setVec) & LIVE_MASK;
    pendD   = ((strobe.rdClr ? '0 : pendQ) | (statD & ~baseVal)) & statD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= RESET_VAL;
      pendQ <= '0;
    end else begin
      statQ <= statD;
      pendQ <= pendD;
    end
  end

  always_comb begin
    statRdData             = '0;
    statRdData[STAT_W-1:0] = statQ;
  end

  assign irq = |(pendQ & intMask);
endmodule

// File: rtl/cardEvtStatus.sv
module cardEvtStatus
  import cardEvtPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EV_W-1:0]   evStrobe,
  input  logic              cmdDone,
  input  logic              xferDone,
  input  logic              rxLoad,
  input  logic              rxRead,
  input  logic              dataRst,
  input  logic              cmdDataClr,
  input  logic              txWrite,
  input  logic              txDrain,
  input  logic              dat3In,
  input  logic              statRd,
  input  logic [STAT_W-1:0] intMask,
  output logic [DATA_W-1:0] statRdData,
  output logic              irq
);
  evtStrobe_t strobe;

  cardEvtCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .evStrobe(evStrobe), .cmdDone(cmdDone),
    .xferDone(xferDone), .rxLoad(rxLoad), .rxRead(rxRead), .dataRst(dataRst),
    .cmdDataClr(cmdDataClr), .txWrite(txWrite), .txDrain(txDrain),
    .dat3In(dat3In), .statRd(statRd), .strobe(strobe)
  );

  cardEvtPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intMask(intMask),
    .statRdData(statRdData), .irq(irq)
  );
endmodule

// File: rtl/cardEvtStatusChk.sv
module cardEvtStatusChk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  evStrobe,
  input logic        cmdDone,
  input logic        xferDone,
  input logic        dataRst,
  input logic        cmdDataClr,
  input logic        rxLoad,
  input logic        txDrain,
  input logic        statRd,
  input logic [13:0] intMask,
  input logic [31:0] statRdData,
  input logic        irq
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    statRdData[31:14] == 18'd0 && !statRdData[8]);

  assert_event_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    evStrobe[0] |=> statRdData[0]);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    statRd && evStrobe == 8'd0 && !cmdDone && !xferDone
    |=> statRdData[7:0] == 8'd0 && statRdData[13:12] == 2'd0);

  assert_event_beats_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    statRd && evStrobe[7] |=> statRdData[7]);

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataRst || cmdDataClr) |=> !statRdData[10]);

  assert_rx_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad && !dataRst && !cmdDataClr |=> statRdData[10]);

  assert_tx_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txDrain || dataRst || cmdDataClr) |=> statRdData[9]);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rstN)
    evStrobe[0] && !statRdData[0] ##1 intMask[0] |-> irq);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    intMask == 14'd0 |-> !irq);
endmodule

bind cardEvtStatus cardEvtStatusChk uChk (
  .clk(clk), .rstN(rstN), .evStrobe(evStrobe), .cmdDone(cmdDone),
  .xferDone(xferDone), .dataRst(dataRst), .cmdDataClr(cmdDataClr),
  .rxLoad(rxLoad), .txDrain(txDrain), .statRd(statRd), .intMask(intMask),
  .statRdData(statRdData), .irq(irq)
);

// File: tb/cardEvtStatus_test.sv
`timescale 1ns/1ps
module cardEvtStatus_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  evStrobe = '0;
  logic        cmdDone = 0, xferDone = 0, rxLoad = 0, rxRead = 0;
  logic        dataRst = 0, cmdDataClr = 0, txWrite = 0, txDrain = 0;
  logic        dat3In = 0, statRd = 0;
  logic [13:0] intMask = '0;
  logic [31:0] statRdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [13:0] mStat, mPend, nStat, nPend;
  logic        mS1, mS2, mLast;

  always #4 clk = ~clk;

  cardEvtStatus uut (
    .clk(clk), .rstN(rstN), .evStrobe(evStrobe), .cmdDone(cmdDone),
    .xferDone(xferDone), .rxLoad(rxLoad), .rxRead(rxRead), .dataRst(dataRst),
    .cmdDataClr(cmdDataClr), .txWrite(txWrite), .txDrain(txDrain),
    .dat3In(dat3In), .statRd(statRd), .intMask(intMask),
    .statRdData(statRdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] nextStat(input logic [13:0] base);
    logic [13:0] n;
    logic clrD;
    n = base;
    clrD = dataRst | cmdDataClr;
    n[7:0] = n[7:0] | evStrobe;
    n[13] = n[13] | cmdDone;
    n[12] = n[12] | xferDone;
    n[11] = n[11] | (mS2 ^ mLast);
    n[10] = clrD ? 1'b0 : rxLoad ? 1'b1 : rxRead ? 1'b0 : mStat[10];
    n[9]  = (clrD | txDrain) ? 1'b1 : txWrite ? 1'b0 : mStat[9];
    n[8]  = 1'b0;
    return n;
  endfunction

  task automatic idle();
    evStrobe = '0; cmdDone = 0; xferDone = 0; rxLoad = 0; rxRead = 0;
    dataRst = 0; cmdDataClr = 0; txWrite = 0; txDrain = 0; statRd = 0;
  endtask

  task automatic tick(input string tag);
    logic [13:0] base;
    base  = statRd ? (mStat & 14'h0600) : mStat;
    nStat = nextStat(base);
    nPend = ((statRd ? 14'd0 : mPend) | (nStat & ~base)) & nStat;
    @(posedge clk);
    @(negedge clk);
    mStat = nStat; mPend = nPend;
    mLast = mS2; mS2 = mS1; mS1 = dat3In;
    chk({tag, " data"}, statRdData, {18'd0, mStat});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(mPend & intMask)});
    chk("R1 reserved", {statRdData[31:14], 13'd0, statRdData[8]}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mStat = 14'h0200; mPend = '0; mS1 = 0; mS2 = 0; mLast = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chk("R2 reset data", statRdData, 32'h0000_0200);
    chk("R2 reset irq", {31'd0, irq}, 32'd0);

    // R3 sticky event
    evStrobe = 8'h08; tick("R3");
    chk("R3 bit3 set", {31'd0, statRdData[3]}, 32'd1);
    idle();
    repeat (3) tick("R3");
    chk("R3 bit3 held", statRdData, 32'h0000_0208);
    cmdDone = 1; xferDone = 1; tick("R3"); idle();
    chk("R3 cmd/xfer set", statRdData, 32'h0000_3208);

    // R4 read shows old value, then clears
    statRd = 1;
    #1 chk("R4 read value", statRdData, 32'h0000_3208);
    tick("R4"); idle();
    chk("R4 cleared", statRdData, 32'h0000_0200);

    // R5 event during read
    evStrobe = 8'h20; statRd = 1; tick("R5"); idle();
    chk("R5 bit5 kept", statRdData, 32'h0000_0220);
    statRd = 1; tick("R5"); idle();

    // R6 receive ready
    rxLoad = 1; tick("R6"); idle();
    chk("R6 load", {31'd0, statRdData[10]}, 32'd1);
    rxLoad = 1; rxRead = 1; tick("R6"); idle();
    chk("R6 load beats read", {31'd0, statRdData[10]}, 32'd1);
    statRd = 1; tick("R6"); idle();
    chk("R6 read ignores rx", {31'd0, statRdData[10]}, 32'd1);
    rxLoad = 1; dataRst = 1; tick("R6"); idle();
    chk("R6 reset beats load", {31'd0, statRdData[10]}, 32'd0);
    rxLoad = 1; tick("R6"); idle();
    cmdDataClr = 1; tick("R6"); idle();
    chk("R6 data clear", {31'd0, statRdData[10]}, 32'd0);
    rxLoad = 1; tick("R6"); idle();
    rxRead = 1; tick("R6"); idle();
    chk("R6 rx read", {31'd0, statRdData[10]}, 32'd0);

    // R7 transmit ready
    txWrite = 1; tick("R7"); idle();
    chk("R7 write clears", {31'd0, statRdData[9]}, 32'd0);
    txWrite = 1; txDrain = 1; tick("R7"); idle();
    chk("R7 set beats write", {31'd0, statRdData[9]}, 32'd1);
    txWrite = 1; tick("R7"); idle();
    dataRst = 1; tick("R7"); idle();
    chk("R7 data reset sets", {31'd0, statRdData[9]}, 32'd1);

    // R8 DAT3 edges
    statRd = 1; tick("R8"); idle();
    dat3In = 1; tick("R8"); tick("R8");
    chk("R8 not yet", {31'd0, statRdData[11]}, 32'd0);
    tick("R8");
    chk("R8 rising seen", {31'd0, statRdData[11]}, 32'd1);
    statRd = 1; tick("R8"); idle();
    dat3In = 0; tick("R8"); tick("R8");
    chk("R8 fall not yet", {31'd0, statRdData[11]}, 32'd0);
    tick("R8");
    chk("R8 falling seen", {31'd0, statRdData[11]}, 32'd1);

    // R9 R10 R11 interrupt
    statRd = 1; tick("R10"); idle();
    intMask = '0; evStrobe = 8'h01; tick("R11"); idle();
    chk("R11 masked off", {31'd0, irq}, 32'd0);
    intMask = 14'h0001;
    #1 chk("R11 mask raises", {31'd0, irq}, 32'd1);
    statRd = 1; tick("R10"); idle();
    chk("R10 read drops irq", {31'd0, irq}, 32'd0);
    evStrobe = 8'h01; tick("R9"); idle();
    chk("R9 rise raises", {31'd0, irq}, 32'd1);
    statRd = 1; tick("R9"); idle();
    intMask = 14'h0200;
    txWrite = 1; tick("R9"); idle();
    txDrain = 1; tick("R9"); idle();
    chk("R9 tx rise", {31'd0, irq}, 32'd1);
    statRd = 1; tick("R10"); idle();
    chk("R10 tx irq retired", {31'd0, irq}, 32'd0);
    chk("R10 tx still set", {31'd0, statRdData[9]}, 32'd1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      evStrobe   = 8'($urandom & $urandom & $urandom);
      cmdDone    = ($urandom % 8) == 0;
      xferDone   = ($urandom % 8) == 0;
      rxLoad     = ($urandom % 6) == 0;
      rxRead     = ($urandom % 6) == 0;
      dataRst    = ($urandom % 20) == 0;
      cmdDataClr = ($urandom % 20) == 0;
      txWrite    = ($urandom % 6) == 0;
      txDrain    = ($urandom % 6) == 0;
      statRd     = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) dat3In = ~dat3In;
      if (($urandom % 32) == 0) intMask = 14'($urandom);
      tick("R9");
    end
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule